// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block resolves the conditional branch group of a 16-bit minicomputer instruction set. Each cycle in which the evaluate strobe is high, it takes the fetched instruction word, the four condition flags (negative, zero, overflow, carry) and the program counter, which has already been advanced past the instruction. From these it decides three things: whether the word is a branch at all, whether the branch is taken, and what the next program counter is.

The condition is selected by a 4-bit code. The code is instruction bit 15 followed by bits 10:8, and it is only valid when bits 14:11 are zero. The code covers one unconditional form, signed comparisons, unsigned comparisons and single-flag tests, each test in a true and a false polarity. The low byte of the word is a signed word offset. The result is registered, so the execute stage consumes it one cycle after the strobe.

Top module: `branch_resolver`

## Requirements
- R1: While rst_ni is low, valid_o, taken_o, not_branch_o and next_pc_o are all zero.
- R2: valid_o is high exactly in the cycle after a cycle with eval_i high, and low otherwise.
- R3: The instruction's high byte selects the test. 0x01 always branches. 0x02 branches when Z is 0, and 0x03 branches when Z is 1.
- R4: Signed tests. 0x04 branches when N xor V is 0, and 0x05 when it is 1. 0x06 branches when (N xor V) or Z is 0, and 0x07 when it is 1.
- R5: Single-flag tests. 0x80 branches on N clear and 0x81 on N set. 0x84 branches on V clear and 0x85 on V set. 0x86 branches on C clear and 0x87 on C set.
- R6: Unsigned tests. 0x82 branches when C and Z are both 0, and 0x83 when C or Z is 1.
- R7: A taken branch gives next_pc_o = pc_i + 2 * sign-extended low byte, modulo 2^16.
- R8: A branch that is not taken gives next_pc_o = pc_i and taken_o = 0, with not_branch_o = 0.
- R9: Any other high byte (for example 0x00, 0x08, 0x88 or 0xFF) gives not_branch_o = 1, taken_o = 0 and next_pc_o = pc_i.
- R10: In cycles without eval_i, taken_o, not_branch_o and next_pc_o hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe |
| instr_i | input | 16 | Fetched instruction word |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| pc_i | input | 16 | Program counter, already incremented |
| valid_o | output | 1 | Result valid, one cycle after eval_i |
| taken_o | output | 1 | Branch taken |
| not_branch_o | output | 1 | Word is not in the branch group |
| next_pc_o | output | 16 | Resulting program counter |

## Verification
The only state is the result register, so an error in it shows at the ports in the cycle after the strobe, and it stays there until the next strobe. A wrong test selection appears as a flipped taken_o for certain flag combinations only. For that reason every branch byte is driven with all sixteen flag combinations. A faulty offset extension or scaling shows in next_pc_o only for negative offsets or offsets near the byte limits, so those boundaries and the 16-bit wrap are driven explicitly. A register that loads without a strobe shows as a changed output during idle cycles.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int unsigned CODE_W = 4;

  // Ordered so that code[3:1] maps directly onto the test.
  typedef enum logic [2:0] {
    TST_ALWAYS = 3'd0,
    TST_Z      = 3'd1,
    TST_NXV    = 3'd2,
    TST_NXVZ   = 3'd3,
    TST_N      = 3'd4,
    TST_CZ     = 3'd5,
    TST_V      = 3'd6,
    TST_C      = 3'd7
  } test_e;

  typedef struct packed {
    logic  is_branch;
    test_e test;
    logic  polarity;  // 1: take when test true, 0: take when test false
  } dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/branch_decode.sv
module branch_decode
  import branch_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 8
) (
  input  logic [DATA_W-1:0] instr_i,
  output dec_t              dec_o
);
  localparam int unsigned SEL_LO = OFFS_W;
  localparam int unsigned SEL_HI = OFFS_W + 2;
  localparam int unsigned GAP_LO = OFFS_W + 3;
  localparam int unsigned GAP_HI = DATA_W - 2;

  logic [CODE_W-1:0] code;

  always_comb begin
    code            = {instr_i[DATA_W-1], instr_i[SEL_HI:SEL_LO]};
    dec_o.is_branch = (instr_i[GAP_HI:GAP_LO] == '0) && (code != '0);
    dec_o.test      = test_e'(code[CODE_W-1:1]);
    dec_o.polarity  = code[0];
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_pkg::*;
(
  input  dec_t   dec_i,
  input  flags_t flags_i,
  output logic   take_o
);
  logic base;
  logic nxv;

  always_comb begin
    nxv = flags_i.n ^ flags_i.v;
    unique case (dec_i.test)
      TST_ALWAYS: base = 1'b1;
      TST_Z:      base = flags_i.z;
      TST_NXV:    base = nxv;
      TST_NXVZ:   base = nxv | flags_i.z;
      TST_N:      base = flags_i.n;
      TST_CZ:     base = flags_i.c | flags_i.z;
      TST_V:      base = flags_i.v;
      TST_C:      base = flags_i.c;
      default:    base = 1'b0;
    endcase
    take_o = dec_i.is_branch & (dec_i.polarity ? base : ~base);
  end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 8
) (
  input  logic [DATA_W-1:0] pc_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [DATA_W-1:0] target_o
);
  localparam int unsigned EXT_W = DATA_W - OFFS_W - 1;

  logic [DATA_W-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i, 1'b0};
    end else begin : g_trunc
      assign disp = {offs_i[DATA_W-2:0], 1'b0};
    end
  endgenerate

  assign target_o = pc_i + disp;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_v_i,
  input  logic              flag_c_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic              not_branch_o,
  output logic [DATA_W-1:0] next_pc_o
);
  dec_t              dec;
  flags_t            flags;
  logic              take;
  logic [DATA_W-1:0] target;

  assign flags = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

  branch_decode #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  branch_cond_eval u_cond (
    .dec_i   (dec),
    .flags_i (flags),
    .take_o  (take)
  );

  branch_target #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_tgt (
    .pc_i     (pc_i),
    .offs_i   (instr_i[OFFS_W-1:0]),
    .target_o (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      taken_o      <= 1'b0;
      not_branch_o <= 1'b0;
      next_pc_o    <= '0;
    end else begin
      valid_o <= eval_i;
      if (eval_i) begin
        taken_o      <= take;
        not_branch_o <= ~dec.is_branch;
        next_pc_o    <= take ? target : pc_i;
      end
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eval_i,
  input logic [DATA_W-1:0] instr_i,
  input logic              flag_n_i,
  input logic              flag_z_i,
  input logic              flag_v_i,
  input logic              flag_c_i,
  input logic [DATA_W-1:0] pc_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic              not_branch_o,
  input logic [DATA_W-1:0] next_pc_o
);
  localparam int unsigned HI_W = DATA_W - OFFS_W;

  logic [HI_W-1:0]   hi;
  logic [DATA_W-1:0] disp2;
  assign hi    = instr_i[DATA_W-1:OFFS_W];
  assign disp2 = DATA_W'($signed(instr_i[OFFS_W-1:0])) << 1;

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_zero: assert (!valid_o && !taken_o && !not_branch_o && next_pc_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> !valid_o);
  a_r3_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && hi == HI_W'(8'h01)) |=> taken_o);
  a_r3_z_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && hi == HI_W'(8'h03)) |=> (taken_o == $past(flag_z_i)));
  a_r4_lt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && hi == HI_W'(8'h05)) |=> (taken_o == $past(flag_n_i ^ flag_v_i)));
  a_r5_v_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && hi == HI_W'(8'h85)) |=> (taken_o == $past(flag_v_i)));
  a_r6_lower_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && hi == HI_W'(8'h83)) |=> (taken_o == $past(flag_c_i | flag_z_i)));
  a_r7_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && taken_o |-> next_pc_o == $past(pc_i) + $past(disp2));
  a_r8_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !taken_o |-> next_pc_o == $past(pc_i));
  a_r9_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_branch_o |-> !taken_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(taken_o) && $stable(not_branch_o) && $stable(next_pc_o));
endmodule

bind branch_resolver branch_resolver_chk #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eval_i       (eval_i),
  .instr_i      (instr_i),
  .flag_n_i     (flag_n_i),
  .flag_z_i     (flag_z_i),
  .flag_v_i     (flag_v_i),
  .flag_c_i     (flag_c_i),
  .pc_i         (pc_i),
  .valid_o      (valid_o),
  .taken_o      (taken_o),
  .not_branch_o (not_branch_o),
  .next_pc_o    (next_pc_o)
);

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [15:0] instr = '0;
  logic        fn = 1'b0, fz = 1'b0, fv = 1'b0, fc = 1'b0;
  logic [15:0] pc = '0;
  logic        valid_o, taken_o, not_branch_o;
  logic [15:0] next_pc_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        taken;
    logic        nb;
    logic [15:0] pc;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .eval_i       (eval),
    .instr_i      (instr),
    .flag_n_i     (fn),
    .flag_z_i     (fz),
    .flag_v_i     (fv),
    .flag_c_i     (fc),
    .pc_i         (pc),
    .valid_o      (valid_o),
    .taken_o      (taken_o),
    .not_branch_o (not_branch_o),
    .next_pc_o    (next_pc_o)
  );

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirement table.
  function automatic void ref_eval(input logic [7:0] hi, input logic n, z, v, c,
                                   output logic is_br, output logic take, output string tag);
    is_br = 1'b1;
    take  = 1'b0;
    case (hi)
      8'h01: begin take = 1'b1;            tag = "R3"; end
      8'h02: begin take = !z;              tag = "R3"; end
      8'h03: begin take = z;               tag = "R3"; end
      8'h04: begin take = (n ^ v) == 0;    tag = "R4"; end
      8'h05: begin take = (n ^ v) == 1;    tag = "R4"; end
      8'h06: begin take = ((n ^ v) | z) == 0; tag = "R4"; end
      8'h07: begin take = ((n ^ v) | z) == 1; tag = "R4"; end
      8'h80: begin take = !n;              tag = "R5"; end
      8'h81: begin take = n;               tag = "R5"; end
      8'h84: begin take = !v;              tag = "R5"; end
      8'h85: begin take = v;               tag = "R5"; end
      8'h86: begin take = !c;              tag = "R5"; end
      8'h87: begin take = c;               tag = "R5"; end
      8'h82: begin take = !c && !z;        tag = "R6"; end
      8'h83: begin take = c || z;          tag = "R6"; end
      default: begin is_br = 1'b0;         tag = "R9"; end
    endcase
  endfunction

  task automatic drive(input logic [7:0] hi, input logic [7:0] off, input logic [3:0] f,
                       input logic [15:0] p);
    exp_t  e;
    logic  is_br, take;
    string tag;
    logic [15:0] disp;
    @(negedge clk);
    eval  = 1'b1;
    instr = {hi, off};
    {fn, fz, fv, fc} = f;
    pc    = p;
    ref_eval(hi, f[3], f[2], f[1], f[0], is_br, take, tag);
    disp    = {{7{off[7]}}, off, 1'b0};
    e.taken = take;
    e.nb    = !is_br;
    e.pc    = take ? p + disp : p;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    eval = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: pop expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        check("R2", "valid_o without pending evaluate", 16'(valid_o), 16'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "taken_o", 16'(taken_o), 16'(e.taken));
        check(e.nb ? "R9" : e.tag, "not_branch_o", 16'(not_branch_o), 16'(e.nb));
        check(e.nb ? "R9" : (e.taken ? "R7" : "R8"), "next_pc_o", next_pc_o, e.pc);
      end
    end
  end

  localparam logic [7:0] BR_HI [15] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                                       8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87};
  localparam logic [7:0] NB_HI [10] = '{8'h00, 8'h08, 8'h10, 8'h40, 8'h7F,
                                       8'h88, 8'h90, 8'hC0, 8'hF8, 8'hFF};

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, inputs active to show they are ignored
    eval  = 1'b1;
    instr = 16'h01_05;
    pc    = 16'h1234;
    repeat (3) @(negedge clk);
    check("R1", "valid_o in reset", 16'(valid_o), 16'h0);
    check("R1", "taken_o in reset", 16'(taken_o), 16'h0);
    check("R1", "not_branch_o in reset", 16'(not_branch_o), 16'h0);
    check("R1", "next_pc_o in reset", next_pc_o, 16'h0);
    eval  = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R3-R8: every branch byte against every flag combination, back to back
    for (int i = 0; i < 15; i++) begin
      for (int f = 0; f < 16; f++) begin
        drive(BR_HI[i], 8'((i * 37 + f * 11) & 255), 4'(f), 16'(16'h1000 + i * 256 + f * 2));
      end
    end
    idle(3);

    // R9: bytes outside the branch group
    for (int i = 0; i < 10; i++) begin
      drive(NB_HI[i], 8'(i * 29), 4'(15 - i), 16'(16'h4000 + i * 6));
      drive(NB_HI[i], 8'h80, 4'(i), 16'(16'h5000 + i * 2));
    end
    idle(3);

    // R7: offset limits and address wrap
    drive(8'h01, 8'h7F, 4'h0, 16'h2000);
    drive(8'h01, 8'h80, 4'h0, 16'h2000);
    drive(8'h01, 8'h00, 4'h0, 16'h2000);
    drive(8'h01, 8'h01, 4'h0, 16'hFFFE);
    drive(8'h01, 8'hFF, 4'h0, 16'h0000);
    drive(8'h87, 8'hFE, 4'h1, 16'h0002);
    idle(3);

    // R10 / R2: hold while idle with changing inputs
    drive(8'h01, 8'h02, 4'h0, 16'h3000);
    idle(1);
    instr = 16'hFF_FF;
    pc    = 16'hABCD;
    {fn, fz, fv, fc} = 4'hF;
    repeat (3) @(negedge clk);
    check("R2", "valid_o while idle", 16'(valid_o), 16'h0);
    check("R10", "taken_o held", 16'(taken_o), 16'h1);
    check("R10", "not_branch_o held", 16'(not_branch_o), 16'h0);
    check("R10", "next_pc_o held", next_pc_o, 16'h3004);

    check("R2", "results outstanding", 16'(sb.size()), 16'h0);
    finish_run();
  end
endmodule